// File: doc/BRIEF.md
# Infrared Transceiver Speed-Mode Programming Sequencer

This block sits on the host side of an infrared transceiver and owns the two control lines that go to it: the shutdown/mode line and the transmit-data line. The transceiver has no speed mode after power-up, and it learns its speed in-band. The host holds the shutdown/mode line high and presents the wanted speed on the transmit line. The falling edge of the shutdown/mode line then latches that level. The level must be stable for a setup window before that edge and must stay for a hold window after it.

A one-cycle program request starts the timed sequence. While the sequence runs, the block drives the transmit line itself and reports busy. When the hold window ends, it pulses done and records the mode. From then on, the transmit data from the link layer passes straight to the transceiver. A shutdown request parks both lines in a safe state: shutdown/mode high and transmit low. It also marks the mode as unknown, so the next wake-up must program the part again. The setup and hold windows are given in nanoseconds. They are turned into clock cycles from the clock period parameter as ceil(window / period) plus one cycle of margin. With the defaults (10 ns clock, 200 ns windows) each window is 21 cycles.

Top module: `irx_mode_seq`

## Requirements
- R1: After reset, sd_mode is 1, tx_line is 0 whatever link_txd is, and busy, done and mode_ok are 0.
- R2: A prog_req while idle raises busy from the next cycle. During the setup phase sd_mode is 1 and tx_line carries prog_fast (1 = high-bandwidth mode 0.576 to 4 Mbit/s, 0 = low-bandwidth mode up to 115.2 kbit/s), and that level is still present when sd_mode falls.
- R3: tx_line holds the requested level with sd_mode high for exactly SETUP_CYC cycles before sd_mode falls, where SETUP_CYC = ceil(SETUP_NS*1000/CLK_PERIOD_PS)+1.
- R4: After sd_mode falls, tx_line keeps the requested level for exactly HOLD_CYC cycles (same formula with HOLD_NS), and then busy drops.
- R5: While busy is 1, changes on link_txd have no effect: tx_line stays at the requested level for the whole sequence.
- R6: done is a one-cycle pulse in the first cycle after busy drops. In that same cycle mode_ok becomes 1 and mode_fast equals the requested level. Neither output changes at any other point of a sequence.
- R7: Once a mode has been programmed, sd_mode is 0 and tx_line follows link_txd in the same cycle.
- R8: A shut_req while idle makes sd_mode 1, tx_line 0 and mode_ok 0 from the next cycle. If shut_req and prog_req arrive in the same idle cycle, the shutdown wins and no sequence starts.
- R9: prog_req and shut_req that arrive while busy is 1 are ignored. The running sequence finishes with its original level and timing, and no second sequence follows.
- R10: A reprogram started from the linked state keeps the previous mode_ok and mode_fast values until the new sequence completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_req | input | 1 | One-cycle request to run the speed programming sequence |
| prog_fast | input | 1 | Requested speed with prog_req: 1 high bandwidth, 0 low bandwidth |
| shut_req | input | 1 | One-cycle request to park the transceiver in shutdown |
| link_txd | input | 1 | Transmit data from the link layer |
| sd_mode | output | 1 | Shutdown/mode line to the transceiver |
| tx_line | output | 1 | Transmit line to the transceiver |
| busy | output | 1 | Programming sequence in progress |
| done | output | 1 | One-cycle pulse when a sequence completes |
| mode_ok | output | 1 | A speed mode has been programmed since the last shutdown |
| mode_fast | output | 1 | Last programmed speed: 1 high bandwidth, 0 low bandwidth |

## Verification
The assertions assume that prog_req and shut_req are synchronous to clk, and that the clock period parameter matches the clock actually applied. If either does not hold, the cycle windows mean nothing in nanoseconds. The stimulus drives every request on the falling clock edge as a single-cycle pulse. It toggles link_txd on every busy cycle so that any leak into tx_line shows up, and it injects its mid-sequence requests only while busy is 1. Around each falling edge of sd_mode, the scoreboard measures the setup and hold runs in whole cycles.

// File: rtl/irx_pkg.sv
package irx_pkg;

    typedef enum logic [1:0] {
        ST_PARK  = 2'd0,
        ST_SETUP = 2'd1,
        ST_HOLD  = 2'd2,
        ST_LINK  = 2'd3
    } irx_state_e;

    typedef struct packed {
        irx_state_e st;
        logic       sel;
        logic       fast;
        logic       valid;
        logic       done;
    } irx_seq_s;

    // window in ns -> whole clock cycles, rounded up, plus one cycle margin
    function automatic int irx_cycles(input int win_ns, input int period_ps);
        return (win_ns * 1000 + period_ps - 1) / period_ps + 1;
    endfunction

endpackage

// File: rtl/irx_phase_timer.sv
module irx_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = clear ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire = (cnt_q == limit - 1'b1);

endmodule

// File: rtl/irx_seq_fsm.sv
module irx_seq_fsm
    import irx_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int SETUP_CYC = 21,
    parameter int HOLD_CYC  = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prog_req,
    input  logic             prog_fast,
    input  logic             shut_req,
    input  logic             expire,
    output irx_state_e       state,
    output logic             sel,
    output logic             fast,
    output logic             valid,
    output logic             done,
    output logic             tmr_clear,
    output logic [CNT_W-1:0] tmr_limit
);

    irx_seq_s seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        tmr_clear  = 1'b1;
        case (seq_q.st)
            ST_PARK, ST_LINK: begin
                if (shut_req) begin
                    seq_d.st    = ST_PARK;
                    seq_d.valid = 1'b0;
                end else if (prog_req) begin
                    seq_d.st  = ST_SETUP;
                    seq_d.sel = prog_fast;
                end
            end
            ST_SETUP: begin
                tmr_clear = expire;
                if (expire) seq_d.st = ST_HOLD;
            end
            ST_HOLD: begin
                tmr_clear = expire;
                if (expire) begin
                    seq_d.st    = ST_LINK;
                    seq_d.fast  = seq_q.sel;
                    seq_d.valid = 1'b1;
                    seq_d.done  = 1'b1;
                end
            end
            default: seq_d.st = ST_PARK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_PARK, sel: 1'b0, fast: 1'b0, valid: 1'b0, done: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign tmr_limit = (seq_q.st == ST_SETUP) ? CNT_W'(SETUP_CYC) : CNT_W'(HOLD_CYC);
    assign state     = seq_q.st;
    assign sel       = seq_q.sel;
    assign fast      = seq_q.fast;
    assign valid     = seq_q.valid;
    assign done      = seq_q.done;

endmodule

// File: rtl/irx_line_mux.sv
module irx_line_mux
    import irx_pkg::*;
(
    input  irx_state_e state,
    input  logic       sel,
    input  logic       link_txd,
    output logic       sd_mode,
    output logic       tx_line
);

    always_comb begin
        case (state)
            ST_SETUP: begin sd_mode = 1'b1; tx_line = sel;      end
            ST_HOLD:  begin sd_mode = 1'b0; tx_line = sel;      end
            ST_LINK:  begin sd_mode = 1'b0; tx_line = link_txd; end
            default:  begin sd_mode = 1'b1; tx_line = 1'b0;     end
        endcase
    end

endmodule

// File: rtl/irx_mode_seq.sv
module irx_mode_seq
    import irx_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 10000,
    parameter int SETUP_NS      = 200,
    parameter int HOLD_NS       = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prog_req,
    input  logic prog_fast,
    input  logic shut_req,
    input  logic link_txd,
    output logic sd_mode,
    output logic tx_line,
    output logic busy,
    output logic done,
    output logic mode_ok,
    output logic mode_fast
);

    localparam int SETUP_CYC = irx_cycles(SETUP_NS, CLK_PERIOD_PS);
    localparam int HOLD_CYC  = irx_cycles(HOLD_NS, CLK_PERIOD_PS);
    localparam int MAX_CYC   = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
    localparam int CNT_W     = $clog2(MAX_CYC + 1);

    irx_state_e       state;
    logic             sel;
    logic             expire;
    logic             tmr_clear;
    logic [CNT_W-1:0] tmr_limit;

    irx_seq_fsm #(
        .CNT_W    (CNT_W),
        .SETUP_CYC(SETUP_CYC),
        .HOLD_CYC (HOLD_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .prog_req (prog_req),
        .prog_fast(prog_fast),
        .shut_req (shut_req),
        .expire   (expire),
        .state    (state),
        .sel      (sel),
        .fast     (mode_fast),
        .valid    (mode_ok),
        .done     (done),
        .tmr_clear(tmr_clear),
        .tmr_limit(tmr_limit)
    );

    irx_phase_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (tmr_clear),
        .limit (tmr_limit),
        .expire(expire)
    );

    irx_line_mux u_mux (
        .state   (state),
        .sel     (sel),
        .link_txd(link_txd),
        .sd_mode (sd_mode),
        .tx_line (tx_line)
    );

    assign busy = (state == ST_SETUP) || (state == ST_HOLD);

endmodule

// File: rtl/irx_mode_seq_chk.sv
module irx_mode_seq_chk #(
    parameter int SETUP_CYC = 21,
    parameter int HOLD_CYC  = 21
) (
    input logic clk,
    input logic rst_n,
    input logic shut_req,
    input logic sd_mode,
    input logic tx_line,
    input logic busy,
    input logic done,
    input logic mode_ok
);

    logic [15:0] set_run_q, hold_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            set_run_q  <= '0;
            hold_run_q <= '0;
        end else begin
            set_run_q  <= (busy && sd_mode)  ? set_run_q + 1'b1  : '0;
            hold_run_q <= (busy && !sd_mode) ? hold_run_q + 1'b1 : '0;
        end
    end

    AST_PARKED_WHEN_UNPROGRAMMED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !mode_ok) |-> (sd_mode && !tx_line)); // R1

    AST_TX_STABLE_AT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !sd_mode && $past(sd_mode)) |-> $stable(tx_line)); // R2

    AST_SETUP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !sd_mode && $past(sd_mode)) |-> (set_run_q == 16'(SETUP_CYC))); // R3

    AST_HOLD_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (hold_run_q == 16'(HOLD_CYC))); // R4

    AST_TX_FROZEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(tx_line)); // R5

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy) && mode_ok)); // R6

    AST_VALID_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_ok) |-> done); // R6

    AST_SHUT_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (shut_req && !busy) |=> (sd_mode && !tx_line && !mode_ok && !busy)); // R8

endmodule

bind irx_mode_seq irx_mode_seq_chk #(
    .SETUP_CYC(SETUP_CYC),
    .HOLD_CYC (HOLD_CYC)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .shut_req(shut_req),
    .sd_mode (sd_mode),
    .tx_line (tx_line),
    .busy    (busy),
    .done    (done),
    .mode_ok (mode_ok)
);

// File: tb/tb_irx_mode_seq.sv
module tb_irx_mode_seq;

    localparam int CLK_PS   = 10000;
    localparam int WIN_NS   = 200;
    localparam int EXP_CYC  = (WIN_NS * 1000 + CLK_PS - 1) / CLK_PS + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic prog_req = 1'b0, prog_fast = 1'b0, shut_req = 1'b0, link_txd = 1'b0;
    logic sd_mode, tx_line, busy, done, mode_ok, mode_fast;

    int n_chk = 0;
    int n_fail = 0;
    bit exp_q[$];
    int set_run, hold_run;
    bit in_hold, seq_lvl, prev_sd, bad_lvl;

    always #(CLK_PS / 2 * 1ps) clk = ~clk;

    irx_mode_seq #(
        .CLK_PERIOD_PS(CLK_PS),
        .SETUP_NS     (WIN_NS),
        .HOLD_NS      (WIN_NS)
    ) dut (
        .clk(clk), .rst_n(rst_n), .prog_req(prog_req), .prog_fast(prog_fast),
        .shut_req(shut_req), .link_txd(link_txd), .sd_mode(sd_mode),
        .tx_line(tx_line), .busy(busy), .done(done), .mode_ok(mode_ok),
        .mode_fast(mode_fast)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // monitor: scoreboard of sequences, samples on the falling edge
    always @(negedge clk) begin
        if (!rst_n) begin
            set_run = 0; hold_run = 0; in_hold = 0; prev_sd = 1; bad_lvl = 0;
        end else begin
            if (busy && sd_mode && exp_q.size() > 0 && tx_line !== exp_q[0]) bad_lvl = 1;
            if (busy && !sd_mode && prev_sd) begin
                chk(exp_q.size() > 0, "R9 unexpected sequence", exp_q.size(), 1);
                if (exp_q.size() > 0) seq_lvl = exp_q.pop_front();
                chk(tx_line == seq_lvl, "R2 level at latch", tx_line, seq_lvl);
                chk(set_run == EXP_CYC, "R3 setup cycles", set_run, EXP_CYC);
                in_hold = 1; hold_run = 1;
            end else if (busy && !sd_mode) begin
                hold_run++;
                if (tx_line !== seq_lvl) bad_lvl = 1;
            end
            if (!busy && in_hold) begin
                chk(hold_run == EXP_CYC, "R4 hold cycles", hold_run, EXP_CYC);
                chk(!bad_lvl, "R5 tx_line frozen while busy", bad_lvl, 0);
                chk(done && mode_ok && mode_fast == seq_lvl, "R6 done/mode",
                    {done, mode_ok, mode_fast}, {2'b11, seq_lvl});
                in_hold = 0; bad_lvl = 0;
            end
            set_run = (busy && sd_mode) ? set_run + 1 : 0;
            prev_sd = sd_mode;
        end
    end

    // driver: pushes expected level, wiggles link_txd during the sequence
    task automatic do_prog(input bit lvl, input bit disturb);
        @(negedge clk);
        prog_req = 1; prog_fast = lvl;
        exp_q.push_back(lvl);
        @(negedge clk);
        prog_req = 0;
        for (int i = 0; busy; i++) begin
            link_txd = ~link_txd;
            if (disturb && i == 5)  begin prog_req = 1; prog_fast = ~lvl; end
            else if (disturb && i == 30) shut_req = 1;
            else begin prog_req = 0; shut_req = 0; end
            @(negedge clk);
        end
        prog_req = 0; shut_req = 0; link_txd = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        link_txd = 1;
        repeat (3) @(negedge clk);
        #1;
        chk(sd_mode && !tx_line && !busy && !done && !mode_ok, "R1 reset state",
            {sd_mode, tx_line, busy, done, mode_ok}, 5'b10000);
        rst_n = 1;
        @(negedge clk); #1;
        chk(sd_mode && !tx_line, "R1 link_txd blocked before programming",
            {sd_mode, tx_line}, 2'b10);
        link_txd = 0;

        // R2 R3 R4: high-bandwidth programming from park
        do_prog(1'b1, 1'b0);
        // R7: pass-through after programming
        link_txd = 1; #1;
        chk(!sd_mode && tx_line, "R7 pass-through high", {sd_mode, tx_line}, 2'b01);
        link_txd = 0; #1;
        chk(!sd_mode && !tx_line, "R7 pass-through low", {sd_mode, tx_line}, 2'b00);

        // R10: reprogram to low bandwidth keeps old mode until done
        @(negedge clk);
        prog_req = 1; prog_fast = 0; exp_q.push_back(1'b0);
        @(negedge clk); prog_req = 0;
        repeat (10) @(negedge clk);
        chk(busy && mode_ok && mode_fast, "R10 old mode kept mid-sequence",
            {busy, mode_ok, mode_fast}, 3'b111);
        while (busy) @(negedge clk);
        @(negedge clk);
        chk(mode_ok && !mode_fast, "R10 new mode after done", {mode_ok, mode_fast}, 2'b10);

        // R8: shutdown while linked
        shut_req = 1; link_txd = 1;
        @(negedge clk); shut_req = 0; #1;
        chk(sd_mode && !tx_line && !mode_ok, "R8 shutdown parks",
            {sd_mode, tx_line, mode_ok}, 3'b100);
        link_txd = 0;

        // R8 priority: both requests together
        @(negedge clk);
        shut_req = 1; prog_req = 1; prog_fast = 1;
        @(negedge clk); shut_req = 0; prog_req = 0;
        chk(!busy && sd_mode && !mode_ok, "R8 shutdown beats program",
            {busy, sd_mode, mode_ok}, 3'b010);

        // R9: requests during a sequence ignored
        do_prog(1'b0, 1'b1);
        repeat (EXP_CYC * 3) @(negedge clk);
        chk(!busy && exp_q.size() == 0, "R9 no extra sequence", busy, 0);
        chk(mode_ok && !mode_fast, "R9 original mode kept", {mode_ok, mode_fast}, 2'b10);

        do_prog(1'b1, 1'b1);
        chk(mode_ok && mode_fast, "R9 high mode kept under disturbance",
            {mode_ok, mode_fast}, 2'b11);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule